// File: doc/BRIEF.md
# Received Word Bit Monitor

This block follows a stream of 32-bit words delivered by eight serial avionics-bus receive channels and drives a set of monitor pins (eight by default). Each pin mirrors one payload bit, taken from words that carry one chosen label on one chosen channel. Outside logic can therefore react to a single received flag without polling the host interface.

Every pin has two 8-bit setup registers. One holds the channel and the bit index, and the other holds the label. A status register shows all pin values, and a write to it presets them. The host reaches these registers over a plain address/data bus. Writes take effect on the clock edge, and reads are combinational.

Received words come in on a valid/ready stream. The block never applies back-pressure: `word_ready` is held high, so every cycle with `word_valid` high transfers one word. The stream carries no other handshake rule.

Top module: `rxbit_monitor`

## Requirements
- R1: After reset, every pin, every setup register and the status register read zero.
- R2: For pin i, the byte at address 0x8060+2i holds the channel in bits 7:5 and the bit index in bits 4:0. The byte at 0x8061+2i holds the 8-bit label. Both read back exactly as written.
- R3: A word updates a pin when all of these hold: `word_valid` is high, `word_chan` equals the pin's channel, that channel's `rx_enable` bit is set, `word_data[7:0]` equals the pin's label, and the bit index is between 8 and 31. The pin then takes `word_data[index]` on the next clock edge.
- R4: A bit index of 0 to 7 turns the pin off for word updates, and the pin keeps its value.
- R5: A word on another channel, a word with another label, and a word on a channel whose `rx_enable` bit is clear all leave the pin unchanged.
- R6: Bit i of the status register at 0x805F reads as pin i. A write to that register loads the pins from the write data on the next clock edge.
- R7: If a status write and a word update reach the same pin in the same cycle, the word update wins for that pin. The other pins take the written value.
- R8: One word can update several pins in the same cycle, and each pin takes its own selected bit.
- R9: A read from any other address returns zero. A write to any other address changes neither a pin nor a register.
- R10: `word_ready` is high in every cycle after reset, so a word offered with `word_valid` is always accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_valid | input | 1 | A received word is present |
| word_ready | output | 1 | Word accepted (always high) |
| word_chan | input | 3 | Channel the word arrived on |
| word_data | input | 32 | Received word; bits 7:0 are the label |
| rx_enable | input | 8 | Per-channel receiver enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| mon_pins | output | 8 | Monitor pin values |

## Verification
The assertions check four things on every cycle. Pins hold their value when no word and no status write are present. A disabled channel never moves a pin. A lone status write lands on the pins. Reads of the status address and of unmapped addresses return what they should. Some behaviours depend on a particular programmed setup, and only the bench's scenarios can show them: the exact bit sampled, the label and channel match, the inert bit indexes 0 to 7, the precedence in a collision, and several pins updating from one word.

// File: rtl/rbm_pkg.sv
package rbm_pkg;
  localparam int WORD_W  = 32;
  localparam int LBL_W   = 8;
  localparam int SEL_W   = 5;
  localparam int CH_W    = 3;
  localparam int NUM_CH  = 1 << CH_W;
  localparam int REG_W   = 8;
  localparam int MIN_BIT = 8;

  typedef struct packed {
    logic [CH_W-1:0]  chan;
    logic [SEL_W-1:0] bitsel;
  } sel_cfg_t;
endpackage

// File: rtl/rbm_cfg_regs.sv
module rbm_cfg_regs
  import rbm_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] CFG_BASE = 16'h8060
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [REG_W-1:0]     reg_wdata,
  output sel_cfg_t             sel_q [NUM_PINS],
  output logic [LBL_W-1:0]     lbl_q [NUM_PINS],
  output logic                 cfg_hit,
  output logic [REG_W-1:0]     cfg_rdata
);
  localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam int SPAN  = 2 * NUM_PINS;

  logic [ADDR_W-1:0] off;
  logic [IDX_W-1:0]  idx;
  logic              odd;

  always_comb begin
    off     = reg_addr - CFG_BASE;
    cfg_hit = (reg_addr >= CFG_BASE) && (off < ADDR_W'(SPAN));
    idx     = off[IDX_W:1];
    odd     = off[0];
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_reg
    logic wr_here;
    assign wr_here = reg_wr && cfg_hit && (int'(idx) == i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q[i] <= '0;
        lbl_q[i] <= '0;
      end else if (wr_here) begin
        if (odd) lbl_q[i] <= reg_wdata;
        else     sel_q[i] <= sel_cfg_t'(reg_wdata);
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_hit) cfg_rdata = odd ? lbl_q[idx] : REG_W'(sel_q[idx]);
  end
endmodule

// File: rtl/rbm_pin_slice.sv
module rbm_pin_slice
  import rbm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_valid,
  input  logic [CH_W-1:0]   word_chan,
  input  logic [WORD_W-1:0] word_data,
  input  logic [NUM_CH-1:0] rx_enable,
  input  sel_cfg_t          sel,
  input  logic [LBL_W-1:0]  lbl,
  input  logic              preset_en,
  input  logic              preset_val,
  output logic              pin_q
);
  logic chan_ok, lbl_ok, bit_ok, hit;

  always_comb begin
    chan_ok = (word_chan == sel.chan) && rx_enable[sel.chan];
    lbl_ok  = (word_data[LBL_W-1:0] == lbl);
    bit_ok  = (int'(sel.bitsel) >= MIN_BIT);
    hit     = word_valid && chan_ok && lbl_ok && bit_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pin_q <= 1'b0;
    else if (hit)       pin_q <= word_data[sel.bitsel];
    else if (preset_en) pin_q <= preset_val;
  end
endmodule

// File: rtl/rxbit_monitor.sv
module rxbit_monitor
  import rbm_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 16'h805F,
  parameter logic [ADDR_W-1:0] CFG_BASE    = 16'h8060
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                word_valid,
  output logic                word_ready,
  input  logic [CH_W-1:0]     word_chan,
  input  logic [WORD_W-1:0]   word_data,
  input  logic [NUM_CH-1:0]   rx_enable,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  output logic [NUM_PINS-1:0] mon_pins
);
  sel_cfg_t         sel_q [NUM_PINS];
  logic [LBL_W-1:0] lbl_q [NUM_PINS];
  logic             cfg_hit;
  logic [REG_W-1:0] cfg_rdata;
  logic             stat_sel, stat_wr;

  assign word_ready = 1'b1;
  assign stat_sel   = (reg_addr == STATUS_ADDR);
  assign stat_wr    = reg_wr && stat_sel;

  rbm_cfg_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .CFG_BASE(CFG_BASE)) u_cfg (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .sel_q(sel_q), .lbl_q(lbl_q),
    .cfg_hit(cfg_hit), .cfg_rdata(cfg_rdata)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    rbm_pin_slice u_slice (
      .clk(clk), .rst_n(rst_n), .word_valid(word_valid),
      .word_chan(word_chan), .word_data(word_data), .rx_enable(rx_enable),
      .sel(sel_q[i]), .lbl(lbl_q[i]),
      .preset_en(stat_wr), .preset_val(reg_wdata[i]),
      .pin_q(mon_pins[i])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (stat_sel)     reg_rdata[NUM_PINS-1:0] = mon_pins;
    else if (cfg_hit) reg_rdata = cfg_rdata;
  end
endmodule

// File: rtl/rbm_checker.sv
module rbm_checker
  import rbm_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 16'h805F,
  parameter logic [ADDR_W-1:0] CFG_BASE    = 16'h8060
) (
  input logic                clk,
  input logic                rst_n,
  input logic                word_valid,
  input logic [CH_W-1:0]     word_chan,
  input logic [NUM_CH-1:0]   rx_enable,
  input logic                reg_wr,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic [REG_W-1:0]    reg_wdata,
  input logic [REG_W-1:0]    reg_rdata,
  input logic [NUM_PINS-1:0] mon_pins
);
  logic swr, unmapped;
  assign swr = reg_wr && (reg_addr == STATUS_ADDR);
  assign unmapped = (reg_addr != STATUS_ADDR) &&
                    ((reg_addr < CFG_BASE) ||
                     (32'(reg_addr) >= 32'(CFG_BASE) + 2 * NUM_PINS));

  AST_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_valid && !swr) |=> $stable(mon_pins)); // R3
  AST_DISABLED_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !rx_enable[word_chan] && !swr) |=> $stable(mon_pins)); // R5
  AST_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    (swr && !word_valid) |=> (mon_pins == $past(reg_wdata[NUM_PINS-1:0]))); // R6
  AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == STATUS_ADDR) |-> (reg_rdata[NUM_PINS-1:0] == mon_pins)); // R6
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |-> (reg_rdata == '0)); // R9
endmodule

bind rxbit_monitor rbm_checker #(
  .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W),
  .STATUS_ADDR(STATUS_ADDR), .CFG_BASE(CFG_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_chan(word_chan),
  .rx_enable(rx_enable), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mon_pins(mon_pins)
);

// File: tb/rxbit_monitor_test.sv
module rxbit_monitor_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_valid = 1'b0;
  logic        word_ready;
  logic [2:0]  word_chan = '0;
  logic [31:0] word_data = '0;
  logic [7:0]  rx_enable = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [7:0]  mon_pins;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rxbit_monitor uut (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_ready(word_ready),
    .word_chan(word_chan), .word_data(word_data), .rx_enable(rx_enable),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mon_pins(mon_pins)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic send(input logic [2:0] ch, input logic [31:0] w);
    @(negedge clk);
    word_valid = 1'b1; word_chan = ch; word_data = w;
    #1 chk("R10 ready", 32'(word_ready), 32'd1);
    @(negedge clk);
    word_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 pins", 32'(mon_pins), 32'h0);
    rd(16'h805F, d); chk("R1 status", 32'(d), 32'h0);
    rd(16'h8060, d); chk("R1 sel0", 32'(d), 32'h0);
    rd(16'h806F, d); chk("R1 lbl7", 32'(d), 32'h0);
  endtask

  task automatic t_cfg();
    logic [7:0] d;
    wr(16'h8066, 8'hB4); wr(16'h8067, 8'h5A);
    wr(16'h8060, 8'h5F); wr(16'h8061, 8'hA3);
    rd(16'h8066, d); chk("R2 sel3", 32'(d), 32'hB4);
    rd(16'h8067, d); chk("R2 lbl3", 32'(d), 32'h5A);
    rd(16'h8060, d); chk("R2 sel0", 32'(d), 32'h5F);
  endtask

  task automatic t_update();
    rx_enable = 8'hFF;
    send(3'd2, 32'h8000_00A3); chk("R3 pin0 set", 32'(mon_pins), 32'h01);
    send(3'd2, 32'h0000_00A3); chk("R3 pin0 clr", 32'(mon_pins), 32'h00);
    send(3'd5, 32'h0010_005A); chk("R3 pin3 bit20", 32'(mon_pins), 32'h08);
  endtask

  task automatic t_bitsel_low();
    wr(16'h8062, 8'h04); wr(16'h8063, 8'h11);
    wr(16'h805F, 8'h00);
    send(3'd0, 32'hFFFF_FF11); chk("R4 low index inert", 32'(mon_pins), 32'h00);
  endtask

  task automatic t_no_match();
    send(3'd3, 32'h8000_00A3); chk("R5 other chan", 32'(mon_pins), 32'h00);
    send(3'd2, 32'h8000_00A4); chk("R5 other label", 32'(mon_pins), 32'h00);
    rx_enable = 8'hFB;
    send(3'd2, 32'h8000_00A3); chk("R5 disabled rx", 32'(mon_pins), 32'h00);
    rx_enable = 8'hFF;
  endtask

  task automatic t_status();
    logic [7:0] d;
    wr(16'h805F, 8'hC5);
    chk("R6 preset pins", 32'(mon_pins), 32'hC5);
    rd(16'h805F, d); chk("R6 status read", 32'(d), 32'hC5);
  endtask

  task automatic t_collision();
    wr(16'h805F, 8'h00);
    @(negedge clk);
    word_valid = 1'b1; word_chan = 3'd2; word_data = 32'h8000_00A3;
    reg_wr = 1'b1; reg_addr = 16'h805F; reg_wdata = 8'hF0;
    @(negedge clk);
    word_valid = 1'b0; reg_wr = 1'b0;
    chk("R7 word beats preset", 32'(mon_pins), 32'hF1);
  endtask

  task automatic t_multi();
    wr(16'h8068, 8'h48); wr(16'h8069, 8'hA3);
    wr(16'h806A, 8'h5E); wr(16'h806B, 8'hA3);
    wr(16'h805F, 8'h01);
    send(3'd2, 32'h4000_01A3);
    chk("R8 multi pins", 32'(mon_pins), 32'h30);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    wr(16'h8070, 8'hFF); wr(16'h0060, 8'hFF); wr(16'h805E, 8'hFF);
    chk("R9 pins kept", 32'(mon_pins), 32'h30);
    rd(16'h8070, d); chk("R9 read 8070", 32'(d), 32'h0);
    rd(16'h805E, d); chk("R9 read 805E", 32'(d), 32'h0);
    rd(16'h8060, d); chk("R9 cfg kept", 32'(d), 32'h5F);
    rd(16'h8061, d); chk("R9 lbl kept", 32'(d), 32'hA3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cfg();
    t_update();
    t_bitsel_low();
    t_no_match();
    t_status();
    t_collision();
    t_multi();
    t_unmapped();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule